// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller for a Dual-Group Digital I/O Card

This block is the interrupt logic of a port-mapped digital I/O card with a 16-byte register window and two parallel-port groups. One input pin per group (bit 3 of that group's port C) is watched for rising edges. A rising edge seen while interrupts are enabled latches a per-group pending flag. A single request line to the host is the OR of the pending flags, gated by an enable flag.

Software controls the block only through the side effects of bus accesses. Both the enable and the disable action use offset 0xB and are told apart by direction: a write enables and a read disables. A write to offset 0xF clears every pending flag. A read of offset 0xF returns the pending state with inverted sense. The trigger pins are asynchronous and are synchronized inside the block. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `dio_edge_irq`

## Requirements
- R1: After reset, interrupts are disabled, no flag is pending, `irq_req` is 0 and a read of offset 0xF returns 0xFF.
- R2: A write to offset 0xB enables interrupt generation, whatever the data value.
- R3: A read of offset 0xB disables interrupt generation and drops `irq_req` on the next cycle. Pending flags are kept, so a later write to 0xB raises `irq_req` again.
- R4: A rising edge on `trig_in[g]` while enabled sets the pending flag of group g. `irq_req` is high no later than the fourth rising clock edge after the input change.
- R5: Rising edges that occur while disabled set no flag, and enabling afterwards does not raise `irq_req` for them.
- R6: A steady-high or falling input sets no flag. A set flag stays set after its input falls, until it is cleared.
- R7: A write to offset 0xF clears all pending flags, whatever the data value.
- R8: A read of offset 0xF returns bits 7..2 as 1, bit 0 as the inverse of the group 0 flag and bit 1 as the inverse of the group 1 flag (0 means pending). Reads of every offset other than 0xF return 0x00.
- R9: Reads and writes of offsets other than 0xB and 0xF have no effect on the enable flag or the pending flags.
- R10: If an edge is detected in the same cycle as a clear write, the flag for that edge ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Register offset of the current access |
| bus_wdata | input | 8 | Write data (its value is ignored by this block) |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_rd | input | 1 | Read strobe, one access per cycle it is high |
| bus_rdata | output | 8 | Read data, combinational from the current offset |
| trig_in | input | 2 | Asynchronous trigger pins, one per group |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
The trigger pins are driven with isolated rising edges on each group, with steady-high levels, with falling levels after a flag is set, and with edges during a disabled window. These patterns separate true edge detection from level sensing, and they show whether flags are sticky and whether enabling is gated. Bus accesses to 0xB and 0xF in both directions, and to unrelated offsets, show which side effects belong to which offset and direction. A directed case lines a clear write up with an edge in the same cycle to fix the priority between the two, and a reset in the middle of operation shows that reset returns the block to its initial state.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] ofs_t;
  typedef logic [DATA_W-1:0] byte_t;
  localparam ofs_t OFS_ENABLE = 4'hB;
  localparam ofs_t OFS_CLEAR  = 4'hF;
endpackage

// File: rtl/dio_irq_rst_sync.sv
module dio_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dio_irq_sync.sv
module dio_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign d_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dio_irq_pend.sv
module dio_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic enable,
  input  logic clear,
  output logic edge_seen,
  output logic pending
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;

  always_comb begin
    prev_d    = sample;
    edge_seen = sample & ~prev_q;
    pend_d    = pend_q;
    if (clear)              pend_d = 1'b0;
    if (edge_seen && enable) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/dio_edge_irq.sv
module dio_edge_irq
  import dio_irq_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_GROUPS-1:0] trig_in,
  output logic                  irq_req
);
  localparam int PAD_W = DATA_W - NUM_GROUPS;

  logic                  rst_sync_n;
  logic                  en_q, en_d;
  logic                  hit_en_wr, hit_en_rd, hit_clr_wr, hit_clr_rd;
  logic [NUM_GROUPS-1:0] trig_sync, edge_det, pend_q;
  logic                  wdata_unused;

  assign wdata_unused = ^bus_wdata;

  dio_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign hit_en_wr  = bus_wr && (bus_addr == OFS_ENABLE);
  assign hit_en_rd  = bus_rd && (bus_addr == OFS_ENABLE);
  assign hit_clr_wr = bus_wr && (bus_addr == OFS_CLEAR);
  assign hit_clr_rd = bus_rd && (bus_addr == OFS_CLEAR);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    dio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .d_async (trig_in[g]),
      .d_sync  (trig_sync[g])
    );
    dio_irq_pend u_pend (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sample    (trig_sync[g]),
      .enable    (en_q),
      .clear     (hit_clr_wr),
      .edge_seen (edge_det[g]),
      .pending   (pend_q[g])
    );
  end

  always_comb begin
    en_d = en_q;
    if (hit_en_rd)      en_d = 1'b0;
    else if (hit_en_wr) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= 1'b0;
    else             en_q <= en_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_clr_rd) bus_rdata = {{PAD_W{1'b1}}, ~pend_q};
  end

  assign irq_req = en_q & (|pend_q);
endmodule

// File: rtl/dio_edge_irq_chk.sv
module dio_edge_irq_chk
  import dio_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic                  irq_req,
  input logic                  en_q,
  input logic [NUM_GROUPS-1:0] pend_q,
  input logic [NUM_GROUPS-1:0] edge_det
);
  assert_enable_on_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_ENABLE) |=> en_q);

  assert_disable_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr == OFS_ENABLE) |=> !irq_req);

  assert_no_set_when_off_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_q |=> ((pend_q & ~$past(pend_q)) == '0));

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_wr && bus_addr == OFS_CLEAR) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_CLEAR) |=> ((pend_q & ~$past(edge_det)) == '0));
endmodule

bind dio_edge_irq dio_edge_irq_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .irq_req    (irq_req),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .edge_det   (edge_det)
);

// File: tb/tb_dio_edge_irq.sv
module tb_dio_edge_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_rdata;
  logic [1:0] trig_in;
  logic       irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .irq_req(irq_req)
  );

  // vector fields: [10:9] op (0 idle, 1 write, 2 read), [8:5] offset,
  // [4:3] trigger level, [2] expected irq, [1:0] expected status low bits
  localparam logic [10:0] VEC [16] = '{
    {2'd1, 4'hB, 2'b00, 1'b0, 2'b11},  // R2 enable
    {2'd0, 4'h0, 2'b01, 1'b1, 2'b10},  // R4 group 0 edge
    {2'd0, 4'h0, 2'b00, 1'b1, 2'b10},  // R6 sticky after fall
    {2'd1, 4'hF, 2'b00, 1'b0, 2'b11},  // R7 clear
    {2'd0, 4'h0, 2'b10, 1'b1, 2'b01},  // R4 group 1 edge
    {2'd2, 4'hB, 2'b10, 1'b0, 2'b01},  // R3 disable keeps flag
    {2'd1, 4'hB, 2'b10, 1'b1, 2'b01},  // R3 re-enable
    {2'd1, 4'hF, 2'b11, 1'b1, 2'b10},  // R6 clear then group 0 edge
    {2'd1, 4'hF, 2'b11, 1'b0, 2'b11},  // R6 steady high
    {2'd2, 4'hB, 2'b00, 1'b0, 2'b11},  // R3 disable
    {2'd0, 4'h0, 2'b11, 1'b0, 2'b11},  // R5 edges while off
    {2'd1, 4'h3, 2'b11, 1'b0, 2'b11},  // R9 other write
    {2'd1, 4'hB, 2'b11, 1'b0, 2'b11},  // R5 no late flag
    {2'd2, 4'h7, 2'b00, 1'b0, 2'b11},  // R9 other read
    {2'd0, 4'h0, 2'b01, 1'b1, 2'b10},  // R9 still enabled
    {2'd1, 4'hE, 2'b01, 1'b1, 2'b10}   // R9 other write no clear
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1, 4: return "R4";
      2, 7, 8: return "R6";
      3: return "R7";
      5, 6, 9: return "R3";
      10, 12: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_op(logic [1:0] op, logic [3:0] ofs);
    @(negedge clk);
    bus_addr  = ofs;
    bus_wdata = {~ofs, ofs};
    bus_wr    = (op == 2'd1);
    bus_rd    = (op == 2'd2);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  // status read without any clock edge during the strobe
  task automatic peek(logic [3:0] ofs, output logic [7:0] val);
    @(negedge clk);
    bus_addr = ofs;
    bus_rd   = 1'b1;
    #1 val   = bus_rdata;
    bus_rd   = 1'b0;
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(3);
    @(negedge clk);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] rv;
    bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; trig_in = '0;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    check("R1 irq", {7'd0, irq_req}, 8'h00);
    peek(4'hF, rv); check("R1 status", rv, 8'hFF);
    trig_in = 2'b11; wait_clk(4);
    @(negedge clk); check("R1 disabled", {7'd0, irq_req}, 8'h00);
    trig_in = 2'b00; wait_clk(4);

    for (int i = 0; i < 16; i++) begin
      bus_op(VEC[i][10:9], VEC[i][8:5]);
      trig_in = VEC[i][4:3];
      wait_clk(4);
      @(negedge clk);
      check(vec_tag(i), {7'd0, irq_req}, {7'd0, VEC[i][2]});
      peek(4'hF, rv);
      check("R8 status", rv, {6'h3F, VEC[i][1:0]});
    end

    // R8 other offset reads zero
    peek(4'h2, rv); check("R8 other offset", rv, 8'h00);

    // R10 edge coincident with clear write
    bus_op(2'd1, 4'hF);
    trig_in = 2'b00; wait_clk(4);
    @(negedge clk); trig_in = 2'b10;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 4'hF; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    peek(4'hF, rv); check("R10 edge wins", rv, 8'hFD);
    check("R10 irq", {7'd0, irq_req}, 8'h01);

    // R1 reset mid-operation
    do_reset();
    check("R1 reset irq", {7'd0, irq_req}, 8'h00);
    peek(4'hF, rv); check("R1 reset status", rv, 8'hFF);

    finish_run();
  end

  initial begin
    wait_clk(20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule